// File: doc/BRIEF.md
# Aliased-View Vector Register File

This block holds sixteen 128-bit vector registers and exposes the same storage through three overlapping views. The quad view addresses whole registers. The double view addresses 64-bit halves. The single view addresses 32-bit quarters. Each view has one combinational read port and one write port, and each port takes a register number in that view's own numbering.

A double or single write is merged into the 128-bit register that contains it. The other lanes of that register keep their values, so a datapath can build or patch a wide register piece by piece. More than one view may write in the same cycle. Where their slices overlap, the wider view wins. Where they fall on disjoint slices of one register, all of them land.

An index past the end of its view raises a per-view error flag. Such a write is dropped, and such a read returns zero.

Top module: `vrf_alias_file`

## Requirements
- R1: After reset, every register reads as zero through all three views.
- R2: Quad index n (0..15) reads and writes all 128 bits of physical register n.
- R3: Double index n (0..31) is bits [64*(n%2)+63 : 64*(n%2)] of physical register n/2, so doubles 2k+1 and 2k together, with 2k+1 in the upper half, equal quad k.
- R4: Single index n (0..31) is bits [32*(n%4)+31 : 32*(n%4)] of physical register n/4, so singles reach only physical registers 0..7.
- R5: A double or single write changes only its own slice, and every other bit of the containing register keeps its value.
- R6: When writes in one cycle overlap on the same bits, quad data wins over double data, and double data wins over single data.
- R7: Writes in one cycle to disjoint slices of the same register all take effect.
- R8: Reads are combinational. In a write cycle they return the old contents, and the new value is visible from the next cycle on.
- R9: A write whose index is out of range (quad above 15, double or single above 31) changes no storage and sets that view's bit of idx_err in the same cycle. The bits are: bit 0 for quad, bit 1 for double, bit 2 for single.
- R10: A read index that is out of range returns zero data and sets that view's idx_err bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears all storage |
| q_rd_idx | input | 6 | Quad view read index |
| q_rd_data | output | 128 | Quad view read data |
| d_rd_idx | input | 6 | Double view read index |
| d_rd_data | output | 64 | Double view read data |
| s_rd_idx | input | 6 | Single view read index |
| s_rd_data | output | 32 | Single view read data |
| q_wr_en | input | 1 | Quad view write enable |
| q_wr_idx | input | 6 | Quad view write index |
| q_wr_data | input | 128 | Quad view write data |
| d_wr_en | input | 1 | Double view write enable |
| d_wr_idx | input | 6 | Double view write index |
| d_wr_data | input | 64 | Double view write data |
| s_wr_en | input | 1 | Single view write enable |
| s_wr_idx | input | 6 | Single view write index |
| s_wr_data | input | 32 | Single view write data |
| idx_err | output | 3 | Per-view out-of-range flag: bit 0 quad, bit 1 double, bit 2 single |

## Verification
The bench sends all three views at one register in one cycle, both with overlapping slices and with disjoint ones. A design with the wrong priority would keep single data where the quad data belongs. A design that overwrote instead of merging would lose the disjoint single lane. Narrow writes into a register full of ones catch a slice that clobbers its neighbours or lands at the wrong lane offset. Writes and reads just past each view's range catch an index that wraps onto a real register instead of being dropped or read as zero.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
   // bit positions inside the per-view error flag
   localparam int ERR_Q = 0;
   localparam int ERR_D = 1;
   localparam int ERR_S = 2;
   localparam int ERR_W = 3;

   // width of a lane selector; never narrower than one bit
   function automatic int lane_sel_w(input int per_row);
      return (per_row > 1) ? $clog2(per_row) : 1;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/vrf_view_dec.sv
// Splits a view index into a physical row and a lane within that row,
// and flags an index beyond the view's register count.
module vrf_view_dec #(
   parameter int IDX_W     = 6,
   parameter int COUNT     = 16,
   parameter int LANE_BITS = 0,
   parameter int PHYS_W    = 4,
   parameter int LANE_W    = 1
) (
   input  logic [IDX_W-1:0]  idx,
   output logic              ok,
   output logic [PHYS_W-1:0] phys,
   output logic [LANE_W-1:0] lane
);
   localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(COUNT);

   assign ok   = {1'b0, idx} < LIMIT;
   assign phys = idx[LANE_BITS +: PHYS_W];

   generate
      if (LANE_BITS == 0) begin : g_whole
         assign lane = '0;
      end else begin : g_split
         assign lane = idx[LANE_BITS-1:0];
      end
   endgenerate
endmodule

// File: rtl/vrf_row_merge.sv
// Next value of one physical row: narrow slices are laid over the old
// contents first, wider ones after, so wider data wins on shared bits.
module vrf_row_merge #(
   parameter int WIDE_W   = 128,
   parameter int MID_W    = 64,
   parameter int NARROW_W = 32,
   parameter int MID_LW   = 1,
   parameter int NAR_LW   = 2
) (
   input  logic [WIDE_W-1:0]   cur,
   input  logic                q_hit,
   input  logic [WIDE_W-1:0]   q_data,
   input  logic                d_hit,
   input  logic [MID_LW-1:0]   d_lane,
   input  logic [MID_W-1:0]    d_data,
   input  logic                s_hit,
   input  logic [NAR_LW-1:0]   s_lane,
   input  logic [NARROW_W-1:0] s_data,
   output logic [WIDE_W-1:0]   nxt,
   output logic                touch
);
   always_comb begin
      nxt = cur;
      if (s_hit) nxt[s_lane*NARROW_W +: NARROW_W] = s_data;
      if (d_hit) nxt[d_lane*MID_W +: MID_W]       = d_data;
      if (q_hit) nxt                              = q_data;
   end

   assign touch = q_hit | d_hit | s_hit;
endmodule

// File: rtl/vrf_view_rd.sv
// One read view: picks a row, then a slice of it; zero when out of range.
module vrf_view_rd #(
   parameter int NUM_WIDE = 16,
   parameter int WIDE_W   = 128,
   parameter int SLICE_W  = 128,
   parameter int PHYS_W   = 4,
   parameter int LANE_W   = 1
) (
   input  logic [NUM_WIDE-1:0][WIDE_W-1:0] rows,
   input  logic                            ok,
   input  logic [PHYS_W-1:0]               phys,
   input  logic [LANE_W-1:0]               lane,
   output logic [SLICE_W-1:0]              data
);
   logic [WIDE_W-1:0] row;

   always_comb begin
      row  = rows[phys];
      data = ok ? row[lane*SLICE_W +: SLICE_W] : '0;
   end
endmodule

// File: rtl/vrf_alias_file.sv
module vrf_alias_file
   import vrf_pkg::*;
#(
   parameter int NUM_WIDE   = 16,
   parameter int WIDE_W     = 128,
   parameter int MID_W      = 64,
   parameter int NARROW_W   = 32,
   parameter int NUM_MID    = 32,
   parameter int NUM_NARROW = 32,
   parameter int IDX_W      = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_W-1:0]    q_rd_idx,
   output logic [WIDE_W-1:0]   q_rd_data,
   input  logic [IDX_W-1:0]    d_rd_idx,
   output logic [MID_W-1:0]    d_rd_data,
   input  logic [IDX_W-1:0]    s_rd_idx,
   output logic [NARROW_W-1:0] s_rd_data,
   input  logic                q_wr_en,
   input  logic [IDX_W-1:0]    q_wr_idx,
   input  logic [WIDE_W-1:0]   q_wr_data,
   input  logic                d_wr_en,
   input  logic [IDX_W-1:0]    d_wr_idx,
   input  logic [MID_W-1:0]    d_wr_data,
   input  logic                s_wr_en,
   input  logic [IDX_W-1:0]    s_wr_idx,
   input  logic [NARROW_W-1:0] s_wr_data,
   output logic [ERR_W-1:0]    idx_err
);
   localparam int PHYS_W   = (NUM_WIDE > 1) ? $clog2(NUM_WIDE) : 1;
   localparam int MID_PER  = WIDE_W / MID_W;
   localparam int NAR_PER  = WIDE_W / NARROW_W;
   localparam int MID_LB   = $clog2(MID_PER);
   localparam int NAR_LB   = $clog2(NAR_PER);
   localparam int MID_LW   = lane_sel_w(MID_PER);
   localparam int NAR_LW   = lane_sel_w(NAR_PER);
   localparam int MID_ROWS = NUM_MID / MID_PER;
   localparam int NAR_ROWS = NUM_NARROW / NAR_PER;

   // ---------------- elaboration-time parameter checks ----------------
   generate
      if (!is_pow2(NUM_WIDE) || !is_pow2(MID_PER) || !is_pow2(NAR_PER))
         begin : g_bad_pow2
            $error("vrf_alias_file: row count and slice ratios must be powers of two");
         end
      if (MID_W * MID_PER != WIDE_W || NARROW_W * NAR_PER != WIDE_W || NAR_PER <= MID_PER)
         begin : g_bad_slice
            $error("vrf_alias_file: slice widths must divide the row, narrow below mid");
         end
      if (MID_ROWS > NUM_WIDE || NAR_ROWS > NUM_WIDE
          || NUM_MID % MID_PER != 0 || NUM_NARROW % NAR_PER != 0)
         begin : g_bad_count
            $error("vrf_alias_file: view counts exceed or misalign with storage");
         end
      if (IDX_W < PHYS_W + NAR_LB || (1 << IDX_W) <= NUM_MID || (1 << IDX_W) <= NUM_NARROW)
         begin : g_bad_idx
            $error("vrf_alias_file: index width cannot express out-of-range values");
         end
   endgenerate

   // ---------------- storage ----------------
   logic [NUM_WIDE-1:0][WIDE_W-1:0] rows_q;

   // ---------------- index decode, read side ----------------
   logic              qr_ok, dr_ok, sr_ok;
   logic [PHYS_W-1:0] qr_phys, dr_phys, sr_phys;
   logic [0:0]        qr_lane;
   logic [MID_LW-1:0] dr_lane;
   logic [NAR_LW-1:0] sr_lane;

   vrf_view_dec #(.IDX_W(IDX_W), .COUNT(NUM_WIDE), .LANE_BITS(0),
                  .PHYS_W(PHYS_W), .LANE_W(1)) u_dec_qr (
      .idx(q_rd_idx), .ok(qr_ok), .phys(qr_phys), .lane(qr_lane));
   vrf_view_dec #(.IDX_W(IDX_W), .COUNT(NUM_MID), .LANE_BITS(MID_LB),
                  .PHYS_W(PHYS_W), .LANE_W(MID_LW)) u_dec_dr (
      .idx(d_rd_idx), .ok(dr_ok), .phys(dr_phys), .lane(dr_lane));
   vrf_view_dec #(.IDX_W(IDX_W), .COUNT(NUM_NARROW), .LANE_BITS(NAR_LB),
                  .PHYS_W(PHYS_W), .LANE_W(NAR_LW)) u_dec_sr (
      .idx(s_rd_idx), .ok(sr_ok), .phys(sr_phys), .lane(sr_lane));

   // ---------------- index decode, write side ----------------
   logic              qw_ok, dw_ok, sw_ok;
   logic [PHYS_W-1:0] qw_phys, dw_phys, sw_phys;
   logic [0:0]        qw_lane;
   logic [MID_LW-1:0] dw_lane;
   logic [NAR_LW-1:0] sw_lane;

   vrf_view_dec #(.IDX_W(IDX_W), .COUNT(NUM_WIDE), .LANE_BITS(0),
                  .PHYS_W(PHYS_W), .LANE_W(1)) u_dec_qw (
      .idx(q_wr_idx), .ok(qw_ok), .phys(qw_phys), .lane(qw_lane));
   vrf_view_dec #(.IDX_W(IDX_W), .COUNT(NUM_MID), .LANE_BITS(MID_LB),
                  .PHYS_W(PHYS_W), .LANE_W(MID_LW)) u_dec_dw (
      .idx(d_wr_idx), .ok(dw_ok), .phys(dw_phys), .lane(dw_lane));
   vrf_view_dec #(.IDX_W(IDX_W), .COUNT(NUM_NARROW), .LANE_BITS(NAR_LB),
                  .PHYS_W(PHYS_W), .LANE_W(NAR_LW)) u_dec_sw (
      .idx(s_wr_idx), .ok(sw_ok), .phys(sw_phys), .lane(sw_lane));

   logic q_go, d_go, s_go;
   assign q_go = q_wr_en & qw_ok;
   assign d_go = d_wr_en & dw_ok;
   assign s_go = s_wr_en & sw_ok;

   // ---------------- per-row merge and update ----------------
   generate
      for (genvar r = 0; r < NUM_WIDE; r++) begin : g_row
         logic              q_hit, d_hit, s_hit, touch;
         logic [WIDE_W-1:0] nxt, row_q;

         assign q_hit = q_go & (qw_phys == PHYS_W'(r));

         // rows past the reach of a narrow view never see its writes
         if (r < MID_ROWS) begin : g_mid_reach
            assign d_hit = d_go & (dw_phys == PHYS_W'(r));
         end else begin : g_mid_none
            assign d_hit = 1'b0;
         end
         if (r < NAR_ROWS) begin : g_nar_reach
            assign s_hit = s_go & (sw_phys == PHYS_W'(r));
         end else begin : g_nar_none
            assign s_hit = 1'b0;
         end

         vrf_row_merge #(.WIDE_W(WIDE_W), .MID_W(MID_W), .NARROW_W(NARROW_W),
                         .MID_LW(MID_LW), .NAR_LW(NAR_LW)) u_merge (
            .cur(row_q), .q_hit(q_hit), .q_data(q_wr_data),
            .d_hit(d_hit), .d_lane(dw_lane), .d_data(d_wr_data),
            .s_hit(s_hit), .s_lane(sw_lane), .s_data(s_wr_data),
            .nxt(nxt), .touch(touch));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     row_q <= '0;
            else if (touch) row_q <= nxt;
         end

         assign rows_q[r] = row_q;
      end
   endgenerate

   // ---------------- read views ----------------
   vrf_view_rd #(.NUM_WIDE(NUM_WIDE), .WIDE_W(WIDE_W), .SLICE_W(WIDE_W),
                 .PHYS_W(PHYS_W), .LANE_W(1)) u_rd_q (
      .rows(rows_q), .ok(qr_ok), .phys(qr_phys), .lane(qr_lane), .data(q_rd_data));
   vrf_view_rd #(.NUM_WIDE(NUM_WIDE), .WIDE_W(WIDE_W), .SLICE_W(MID_W),
                 .PHYS_W(PHYS_W), .LANE_W(MID_LW)) u_rd_d (
      .rows(rows_q), .ok(dr_ok), .phys(dr_phys), .lane(dr_lane), .data(d_rd_data));
   vrf_view_rd #(.NUM_WIDE(NUM_WIDE), .WIDE_W(WIDE_W), .SLICE_W(NARROW_W),
                 .PHYS_W(PHYS_W), .LANE_W(NAR_LW)) u_rd_s (
      .rows(rows_q), .ok(sr_ok), .phys(sr_phys), .lane(sr_lane), .data(s_rd_data));

   // ---------------- range flags ----------------
   assign idx_err[ERR_Q] = ~qr_ok | (q_wr_en & ~qw_ok);
   assign idx_err[ERR_D] = ~dr_ok | (d_wr_en & ~dw_ok);
   assign idx_err[ERR_S] = ~sr_ok | (s_wr_en & ~sw_ok);
endmodule

// File: rtl/vrf_alias_chk.sv
module vrf_alias_chk
   import vrf_pkg::*;
#(
   parameter int NUM_WIDE   = 16,
   parameter int WIDE_W     = 128,
   parameter int MID_W      = 64,
   parameter int NARROW_W   = 32,
   parameter int NUM_MID    = 32,
   parameter int NUM_NARROW = 32,
   parameter int IDX_W      = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic [IDX_W-1:0]    q_rd_idx,
   input logic [WIDE_W-1:0]   q_rd_data,
   input logic [IDX_W-1:0]    d_rd_idx,
   input logic [MID_W-1:0]    d_rd_data,
   input logic [IDX_W-1:0]    s_rd_idx,
   input logic [NARROW_W-1:0] s_rd_data,
   input logic                q_wr_en,
   input logic [IDX_W-1:0]    q_wr_idx,
   input logic [WIDE_W-1:0]   q_wr_data,
   input logic                d_wr_en,
   input logic [IDX_W-1:0]    d_wr_idx,
   input logic [MID_W-1:0]    d_wr_data,
   input logic                s_wr_en,
   input logic [IDX_W-1:0]    s_wr_idx,
   input logic [NARROW_W-1:0] s_wr_data,
   input logic [ERR_W-1:0]    idx_err
);
   localparam int MID_PER = WIDE_W / MID_W;
   localparam int NAR_PER = WIDE_W / NARROW_W;
   localparam int MID_LB  = $clog2(MID_PER);
   localparam int NAR_LB  = $clog2(NAR_PER);
   localparam logic [IDX_W:0] Q_LIM = (IDX_W+1)'(NUM_WIDE);
   localparam logic [IDX_W:0] D_LIM = (IDX_W+1)'(NUM_MID);
   localparam logic [IDX_W:0] S_LIM = (IDX_W+1)'(NUM_NARROW);

   logic qw_in, dw_in, sw_in, qr_in;
   logic q_over_d, q_over_s, d_over_s, any_go;
   logic [IDX_W-1:0] q_as_d;

   assign qw_in    = {1'b0, q_wr_idx} < Q_LIM;
   assign dw_in    = {1'b0, d_wr_idx} < D_LIM;
   assign sw_in    = {1'b0, s_wr_idx} < S_LIM;
   assign qr_in    = {1'b0, q_rd_idx} < Q_LIM;
   assign q_over_d = q_wr_en && qw_in && (q_wr_idx == (d_wr_idx >> MID_LB));
   assign q_over_s = q_wr_en && qw_in && (q_wr_idx == (s_wr_idx >> NAR_LB));
   assign d_over_s = d_wr_en && dw_in && (d_wr_idx == (s_wr_idx >> (NAR_LB - MID_LB)));
   assign any_go   = (q_wr_en && qw_in) || (d_wr_en && dw_in) || (s_wr_en && sw_in);
   assign q_as_d   = q_rd_idx << MID_LB;

   // R2, R8: an in-range quad write shows at the quad port one cycle on
   p_quad_write_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (q_wr_en && qw_in) |=>
         (q_rd_idx != $past(q_wr_idx) || q_rd_data == $past(q_wr_data)));

   // R6: an unshadowed double write shows at the double port next cycle
   p_double_write_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (d_wr_en && dw_in && !q_over_d) |=>
         (d_rd_idx != $past(d_wr_idx) || d_rd_data == $past(d_wr_data)));

   // R5: an unshadowed single write shows at the single port next cycle
   p_single_write_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (s_wr_en && sw_in && !q_over_s && !d_over_s) |=>
         (s_rd_idx != $past(s_wr_idx) || s_rd_data == $past(s_wr_data)));

   // R9: with no in-range write, a held quad read index keeps its data
   p_hold_without_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !any_go |=> (!$stable(q_rd_idx) || $stable(q_rd_data)));

   // R10: out-of-range quad read gives zero and raises the quad flag
   p_oob_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !qr_in |-> (q_rd_data == '0 && idx_err[ERR_Q]));

   // R3: the lower double of a quad register matches the quad's low half
   p_alias_low_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (qr_in && d_rd_idx == q_as_d) |-> d_rd_data == q_rd_data[MID_W-1:0]);
endmodule

bind vrf_alias_file vrf_alias_chk #(
   .NUM_WIDE(NUM_WIDE), .WIDE_W(WIDE_W), .MID_W(MID_W), .NARROW_W(NARROW_W),
   .NUM_MID(NUM_MID), .NUM_NARROW(NUM_NARROW), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/sim_vrf_alias_file.sv
module sim_vrf_alias_file;
   localparam int CLK_P = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [5:0]   q_rd_idx = '0, d_rd_idx = '0, s_rd_idx = '0;
   logic [127:0] q_rd_data;
   logic [63:0]  d_rd_data;
   logic [31:0]  s_rd_data;
   logic         q_wr_en = 1'b0, d_wr_en = 1'b0, s_wr_en = 1'b0;
   logic [5:0]   q_wr_idx = '0, d_wr_idx = '0, s_wr_idx = '0;
   logic [127:0] q_wr_data = '0;
   logic [63:0]  d_wr_data = '0;
   logic [31:0]  s_wr_data = '0;
   logic [2:0]   idx_err;

   int checks = 0;
   int errors = 0;
   logic [127:0] mdl [16];

   vrf_alias_file u0 (.*);

   initial forever #(CLK_P/2) clk = ~clk;

   function automatic logic [127:0] exp_q(input int i);
      return (i < 16) ? mdl[i] : 128'h0;
   endfunction
   function automatic logic [63:0] exp_d(input int i);
      return (i < 32) ? mdl[i/2][(i%2)*64 +: 64] : 64'h0;
   endfunction
   function automatic logic [31:0] exp_s(input int i);
      return (i < 32) ? mdl[i/4][(i%4)*32 +: 32] : 32'h0;
   endfunction

   task automatic cmp(input string tag, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // one clock: compare outputs mid-cycle, then update the model at the edge
   task automatic cycle(input string tag);
      logic [2:0] e;
      #2;
      e[0] = (q_rd_idx >= 16) || (q_wr_en && q_wr_idx >= 16);
      e[1] = (d_rd_idx >= 32) || (d_wr_en && d_wr_idx >= 32);
      e[2] = (s_rd_idx >= 32) || (s_wr_en && s_wr_idx >= 32);
      cmp(tag, "quad read",   q_rd_data,          exp_q(int'(q_rd_idx)));
      cmp(tag, "double read", {64'h0, d_rd_data}, {64'h0, exp_d(int'(d_rd_idx))});
      cmp(tag, "single read", {96'h0, s_rd_data}, {96'h0, exp_s(int'(s_rd_idx))});
      cmp(tag, "idx_err",     {125'h0, idx_err},  {125'h0, e});
      @(posedge clk);
      if (rst_n) begin
         // lowest priority first so wider writes land on top
         if (s_wr_en && s_wr_idx < 32)
            mdl[s_wr_idx/4][(s_wr_idx%4)*32 +: 32] = s_wr_data;
         if (d_wr_en && d_wr_idx < 32)
            mdl[d_wr_idx/2][(d_wr_idx%2)*64 +: 64] = d_wr_data;
         if (q_wr_en && q_wr_idx < 16)
            mdl[q_wr_idx] = q_wr_data;
      end
      @(negedge clk);
   endtask

   task automatic idle();
      q_wr_en = 0; d_wr_en = 0; s_wr_en = 0;
   endtask
   task automatic rd(input int q, input int d, input int s);
      q_rd_idx = 6'(q); d_rd_idx = 6'(d); s_rd_idx = 6'(s);
   endtask
   task automatic wq(input int i, input logic [127:0] v);
      q_wr_en = 1; q_wr_idx = 6'(i); q_wr_data = v;
   endtask
   task automatic wd(input int i, input logic [63:0] v);
      d_wr_en = 1; d_wr_idx = 6'(i); d_wr_data = v;
   endtask
   task automatic ws(input int i, input logic [31:0] v);
      s_wr_en = 1; s_wr_idx = 6'(i); s_wr_data = v;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: every register empty through every view
      for (int i = 0; i < 32; i++) begin
         rd(i % 16, i, 31 - i);
         cycle("R1");
      end

      // R2 / R8: quad write, old data in the write cycle, new data after
      rd(3, 6, 12);
      wq(3, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210);
      cycle("R8"); idle();
      cycle("R2");

      // R3: double 7 is the upper half of physical row 3
      wd(7, 64'hdead_beef_cafe_f00d); rd(3, 7, 13);
      cycle("R3"); idle();
      cycle("R3");
      rd(3, 6, 14); cycle("R3");

      // R4: single 13 is lane 1 of row 3; single 31 is lane 3 of row 7
      ws(13, 32'h1357_9bdf); rd(3, 13, 13);
      cycle("R4"); idle();
      cycle("R4");
      ws(31, 32'haaaa_5555); rd(7, 15, 31);
      cycle("R4"); idle();
      cycle("R4");

      // R5: narrow writes into an all-ones register keep the rest
      wq(5, '1); cycle("R5"); idle();
      ws(21, 32'h0000_0000); rd(5, 10, 20);
      cycle("R5"); idle();
      cycle("R5");
      wd(11, 64'h0); rd(5, 11, 23);
      cycle("R5"); idle();
      cycle("R5");

      // R6: all three views overlap on row 2 -> quad wins
      wq(2, {4{32'h2222_2222}}); wd(4, {2{32'h4444_4444}}); ws(9, 32'h9999_9999);
      rd(2, 4, 9);
      cycle("R6"); idle();
      cycle("R6");
      // R6: double and single overlap (single 9 inside double 4) -> double wins
      wd(4, 64'h4040_4040_0404_0404); ws(9, 32'h9090_9090);
      cycle("R6"); idle();
      cycle("R6");

      // R7: disjoint slices of row 2 both land
      wd(5, 64'h5555_0000_5555_0000); ws(8, 32'h8888_8888); rd(2, 5, 8);
      cycle("R7"); idle();
      cycle("R7");
      rd(2, 4, 9); cycle("R7");

      // R9: out-of-range writes change nothing and flag their view
      wq(16, '1); wd(32, '1); ws(63, '1); rd(0, 0, 0);
      cycle("R9"); idle();
      for (int i = 0; i < 16; i++) begin
         rd(i, 2*i + 1, 2*i);
         cycle("R9");
      end

      // R10: out-of-range reads give zero and raise the flag
      rd(16, 32, 32); cycle("R10");
      rd(63, 63, 40); cycle("R10");
      rd(15, 31, 33); cycle("R10");

      // mixed traffic, occasionally out of range and colliding
      for (int n = 0; n < 600; n++) begin
         q_wr_en   = ($urandom_range(0, 3) == 0);
         d_wr_en   = ($urandom_range(0, 2) == 0);
         s_wr_en   = ($urandom_range(0, 1) == 0);
         q_wr_idx  = 6'($urandom_range(0, 17));
         d_wr_idx  = 6'($urandom_range(0, 33));
         s_wr_idx  = 6'($urandom_range(0, 33));
         q_wr_data = {$urandom, $urandom, $urandom, $urandom};
         d_wr_data = {$urandom, $urandom};
         s_wr_data = $urandom;
         rd($urandom_range(0, 17), $urandom_range(0, 33), $urandom_range(0, 33));
         cycle("R5");
      end
      idle();
      for (int i = 0; i < 16; i++) begin
         rd(i, 2*i, 2*i + 1);
         cycle("R3");
      end

      summary();
      $finish;
   end
endmodule